// File: doc/BRIEF.md
# Eight-Lane Fixed-Point Rotation Half-Butterfly

This block is the multiply-and-round kernel of a fixed-point trigonometric transform stage. For each of eight lanes it forms the weighted sum of two signed 32-bit data words, using a pair of signed 32-bit cosine weights that all lanes share. It then adds a rounding offset of half a unit at the chosen precision and shifts the sum arithmetically right by that precision. The block takes one operand set per clock and returns eight results two clocks later with a valid flag.

The weights are plain inputs, so the cosine table is kept outside the block. A subtraction is requested by passing a weight as a two's-complement negative value. All arithmetic keeps 32 bits and wraps, as in a lane-wise integer vector unit, so no accumulator is wider than a data word. Stage ordering and the choice of weights belong to the controller that surrounds the block.

Top module: `hbf_rot_array`

## Requirements
- R1: For every lane i, with s = (w0*n0[i] + w1*n1[i] + 2^(prec-1)) mod 2^32, the lane result equals s read as signed and shifted arithmetically right by prec. Lane i occupies bits [32*i+31 : 32*i] of the data buses.
- R2: Each product keeps only the low 32 bits of the full signed product; the upper bits are dropped.
- R3: The sum of the two products and the rounding offset wraps modulo 2^32; a carry out of bit 31 is lost.
- R4: The rounding offset is 2^(prec-1), so a remainder of exactly one half rounds toward plus infinity. At prec=10, inputs 512, 511, -512 and -513 with unit weight give 1, 0, 0 and -1.
- R5: A negative weight given in two's complement yields a difference of the weighted terms, with no separate subtract mode.
- R6: The eight lanes are independent: lane i depends only on n0[i], n1[i] and the shared weights and precision.
- R7: out_valid rises exactly two clocks after an accepted in_valid. Operand sets may arrive on back-to-back clocks, and each result appears in the order of its input.
- R8: While reset is asserted, and after it is released until a new operand set is accepted, out_valid stays low even if in_valid is high during reset.
- R9: Cycles with in_valid low do not change out_data. The last result stays on the output whatever values the data, weight and precision inputs take.
- R10: prec takes legal values 10 to 13 while in_valid is high, and each of them sets both the shift amount and the rounding offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand set present this cycle |
| prec | input | 4 | Cosine precision: shift amount, legal 10..13 |
| w0 | input | 32 | Signed weight for the n0 terms, shared by all lanes |
| w1 | input | 32 | Signed weight for the n1 terms, shared by all lanes |
| n0 | input | 256 | Eight signed 32-bit first operands, lane i at bits 32i+31:32i |
| n1 | input | 256 | Eight signed 32-bit second operands, same packing |
| out_valid | output | 1 | Results on out_data are new this cycle |
| out_data | output | 256 | Eight signed 32-bit results, same packing |

## Verification
Moderate cosine-like weights with a spread of positive and negative lane data are run at each of the four precisions. This shows whether the shift amount and the rounding offset both follow prec. Near-full-scale weights and data force products and sums past 32 bits, which separates wrapping arithmetic from a wide accumulator or from saturation. Inputs that sit on exact half-unit ties, on both signs, separate round-half-up from truncation or round-to-even. Data that differs per lane, together with a stream that has gaps and varies its precision, exposes crossed lanes, a wrong latency and a loss of order. Idle cycles with changing inputs show that the output register is held.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  localparam int unsigned HBF_DW      = 32;
  localparam int unsigned HBF_PW      = 4;
  localparam int unsigned HBF_LANES   = 8;
  localparam int unsigned HBF_MIN_PRC = 10;
  localparam int unsigned HBF_MAX_PRC = 13;

  typedef logic [HBF_DW-1:0] hbf_word_t;
endpackage

// File: rtl/hbf_rst_sync.sv
module hbf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hbf_lane_mul.sv
module hbf_lane_mul #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic [DW-1:0] w0,
  input  logic [DW-1:0] w1,
  input  logic [DW-1:0] n0,
  input  logic [DW-1:0] n1,
  output logic [DW-1:0] p0,
  output logic [DW-1:0] p1
);
  logic [DW-1:0] p0_d, p1_d;
  logic [DW-1:0] p0_q, p1_q;

  // low DW bits of a two's-complement product do not depend on signedness
  always_comb begin
    p0_d = w0 * n0;
    p1_d = w1 * n1;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      p0_q <= p0_d;
      p1_q <= p1_d;
    end
  end

  assign p0 = p0_q;
  assign p1 = p1_q;
endmodule

// File: rtl/hbf_round_shift.sv
module hbf_round_shift #(
  parameter int unsigned DW = 32,
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          en,
  input  logic [PW-1:0] prec,
  input  logic [DW-1:0] p0,
  input  logic [DW-1:0] p1,
  output logic [DW-1:0] res
);
  logic [DW-1:0] half_d;
  logic [DW-1:0] sum_d;
  logic [DW-1:0] res_d;
  logic [DW-1:0] res_q;

  always_comb begin
    half_d = DW'(1) << (prec - PW'(1));
    sum_d  = p0 + p1 + half_d;
    res_d  = $signed(sum_d) >>> prec;
  end

  always_ff @(posedge clk) begin
    if (en) res_q <= res_d;
  end

  assign res = res_q;
endmodule

// File: rtl/hbf_rot_array.sv
module hbf_rot_array
  import hbf_pkg::*;
#(
  parameter int unsigned LANES   = HBF_LANES,
  parameter int unsigned DW      = HBF_DW,
  parameter int unsigned PW      = HBF_PW,
  parameter int unsigned MIN_PRC = HBF_MIN_PRC,
  parameter int unsigned MAX_PRC = HBF_MAX_PRC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [PW-1:0]       prec,
  input  logic [DW-1:0]       w0,
  input  logic [DW-1:0]       w1,
  input  logic [LANES*DW-1:0] n0,
  input  logic [LANES*DW-1:0] n1,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_data
);
  localparam int unsigned BUS_W  = LANES * DW;
  localparam int unsigned SGN_HI = MIN_PRC + 1;

  logic          rst_sync_n;
  logic          s1_en, s2_en;
  logic          v1_d, v2_d;
  logic          v1_q, v2_q;
  logic [PW-1:0] prec_q;

  hbf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // explicit clock enables for both data stages
  assign s1_en = in_valid;
  assign s2_en = v1_q;

  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_en) prec_q <= prec;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0] lp0, lp1;

    hbf_lane_mul #(.DW(DW)) u_mul (
      .clk (clk),
      .en  (s1_en),
      .w0  (w0),
      .w1  (w1),
      .n0  (n0[g*DW +: DW]),
      .n1  (n1[g*DW +: DW]),
      .p0  (lp0),
      .p1  (lp1)
    );

    hbf_round_shift #(.DW(DW), .PW(PW)) u_rnd (
      .clk  (clk),
      .en   (s2_en),
      .prec (prec_q),
      .p0   (lp0),
      .p1   (lp1),
      .res  (out_data[g*DW +: DW])
    );

    // R1: a shift of at least MIN_PRC leaves the top bits as copies of the sign
    a_r1_sign_ext: assert property (@(posedge clk) disable iff (!rst_sync_n)
      out_valid |-> (out_data[g*DW+DW-1 -: SGN_HI] == '0 ||
                     out_data[g*DW+DW-1 -: SGN_HI] == '1));
  end

  assign out_valid = v2_q;

  a_r7_stage1_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> v1_q);
  a_r7_output_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    v1_q |=> out_valid);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !v1_q |=> !out_valid);
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !v1_q |=> $stable(out_data));
  a_r10_prec_legal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |-> (prec >= PW'(MIN_PRC) && prec <= PW'(MAX_PRC)));
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (!out_valid && !v1_q));

  logic unused_bus_w;
  assign unused_bus_w = (BUS_W == 0);
endmodule

// File: tb/hbf_rot_array_tb.sv
module hbf_rot_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int L = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [3:0]    prec;
  logic [31:0]   w0, w1;
  logic [L*32-1:0] n0, n1;
  logic          out_valid;
  logic [L*32-1:0] out_data;

  logic [31:0] n0a [L];
  logic [31:0] n1a [L];

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < L; i++) begin
      n0[i*32 +: 32] = n0a[i];
      n1[i*32 +: 32] = n1a[i];
    end
  end

  hbf_rot_array u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .prec (prec),
    .w0 (w0), .w1 (w1), .n0 (n0), .n1 (n1),
    .out_valid (out_valid), .out_data (out_data)
  );

  function automatic logic [31:0] model(logic [31:0] a0, logic [31:0] b0,
                                        logic [31:0] a1, logic [31:0] b1,
                                        int p);
    logic [31:0] s;
    s = a0 * b0 + a1 * b1 + (32'd1 << (p - 1));
    return $signed(s) >>> p;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane(int i);
    return out_data[i*32 +: 32];
  endfunction

  // drive at a negedge, check at the negedge two clocks later
  task automatic shot(string req, logic [3:0] p);
    logic [31:0] e [L];
    for (int i = 0; i < L; i++) e[i] = model(w0, n0a[i], w1, n1a[i], int'(p));
    prec = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R7 no early valid"}, 32'(out_valid), 32'd0);
    @(negedge clk);
    chk({req, " R7 valid at 2"}, 32'(out_valid), 32'd1);
    for (int i = 0; i < L; i++) chk(req, lane(i), e[i]);
    @(negedge clk);
    chk({req, " R7 single pulse"}, 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    in_valid = 1'b1; prec = 4'd10;
    repeat (3) begin
      @(negedge clk);
      chk("R8 valid low in reset", 32'(out_valid), 32'd0);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 valid low after release", 32'(out_valid), 32'd0);
  endtask

  task automatic t_basic;
    w0 = 32'd2896; w1 = 32'd1567;
    for (int i = 0; i < L; i++) begin
      n0a[i] = 32'(i * 1013 - 3500);
      n1a[i] = 32'(2700 - i * 777);
    end
    for (int p = 10; p <= 13; p++) shot("R1 R10 basic", 4'(p));
  endtask

  task automatic t_wrap;
    w0 = 32'h7fff_fff3; w1 = 32'h8000_0011;
    for (int i = 0; i < L; i++) begin
      n0a[i] = 32'h7654_3210 + 32'(i * 32'h0101_0101);
      n1a[i] = 32'h9abc_def0 - 32'(i * 32'h0303_0303);
    end
    shot("R2 R3 wrap", 4'd12);
  endtask

  task automatic t_round;
    logic [31:0] ex [L];
    w0 = 32'd1; w1 = 32'd0;
    n0a[0] = 32'd512;   ex[0] = 32'd1;
    n0a[1] = 32'd511;   ex[1] = 32'd0;
    n0a[2] = -32'd512;  ex[2] = 32'd0;
    n0a[3] = -32'd513;  ex[3] = 32'hffff_ffff;
    n0a[4] = 32'd1536;  ex[4] = 32'd2;
    n0a[5] = -32'd1536; ex[5] = 32'hffff_ffff;
    n0a[6] = 32'd0;     ex[6] = 32'd0;
    n0a[7] = 32'd1024;  ex[7] = 32'd1;
    for (int i = 0; i < L; i++) n1a[i] = 32'h1234_5678;
    prec = 4'd10; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R4 valid", 32'(out_valid), 32'd1);
    for (int i = 0; i < L; i++) chk("R4 half rounds up", lane(i), ex[i]);
  endtask

  task automatic t_negw;
    w0 = 32'd3784; w1 = -32'd3784;
    for (int i = 0; i < L; i++) begin
      n0a[i] = 32'(i * 4096);
      n1a[i] = 32'(i * 2048 + (i % 2) * 5);
    end
    shot("R5 negative weight", 4'd12);
    n1a[0] = 32'd0; n0a[0] = 32'd4096;
    w1 = -32'd1;
    shot("R5 negative weight 2", 4'd11);
  endtask

  task automatic t_lanes;
    w0 = 32'd4017; w1 = 32'd799;
    for (int i = 0; i < L; i++) begin
      n0a[i] = 32'((i + 1) * 100000) ^ 32'(i << 3);
      n1a[i] = -32'((L - i) * 70001);
    end
    shot("R6 lanes distinct", 4'd13);
    n0a[3] = 32'h4000_0000; n1a[3] = 32'h0000_0001;
    shot("R6 one lane changed", 4'd13);
  endtask

  task automatic t_stream;
    localparam int N = 14;
    bit          v  [N];
    logic [31:0] ex [N][L];
    for (int t = 0; t < N; t++) v[t] = (t % 5 != 3) && (t < N - 2);
    for (int t = 0; t < N; t++) begin
      if (t >= 2) begin
        chk("R7 stream valid", 32'(out_valid), 32'(v[t-2]));
        if (v[t-2])
          for (int i = 0; i < L; i++) chk("R7 stream order", lane(i), ex[t-2][i]);
      end
      w0 = 32'(1000 + t * 17); w1 = -32'(300 + t * 5);
      prec = 4'(10 + (t % 4));
      for (int i = 0; i < L; i++) begin
        n0a[i] = 32'(t * 5003 + i * 919 - 20000);
        n1a[i] = 32'(i * 4001 - t * 1237);
        ex[t][i] = model(w0, n0a[i], w1, n1a[i], int'(prec));
      end
      in_valid = v[t];
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_hold;
    logic [L*32-1:0] snap;
    w0 = 32'd181; w1 = 32'd181;
    for (int i = 0; i < L; i++) begin n0a[i] = 32'(i * 999); n1a[i] = 32'(i * 333); end
    shot("R9 setup", 4'd10);
    snap = out_data;
    for (int k = 0; k < 4; k++) begin
      w0 = 32'(k * 77 + 5); w1 = -32'(k + 9); prec = 4'(10 + k);
      for (int i = 0; i < L; i++) begin n0a[i] = 32'(k * 31 + i); n1a[i] = ~32'(i); end
      @(negedge clk);
      chk("R9 idle hold", out_data[31:0], snap[31:0]);
      chk("R9 idle hold top", out_data[L*32-1 -: 32], snap[L*32-1 -: 32]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; prec = 4'd10; w0 = '0; w1 = '0;
    for (int i = 0; i < L; i++) begin n0a[i] = '0; n1a[i] = '0; end
    t_reset();
    t_basic();
    t_wrap();
    t_round();
    t_negw();
    t_lanes();
    t_stream();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule